// File: doc/BRIEF.md
# Interruptible Block-Move Sequencer

This block runs one byte-copy instruction of a processor core, either ascending or descending through memory. The instruction is three bytes long: an opcode, then the destination bank, then the source bank. When it starts, the core hands over the instruction address, the 16-bit source offset (X), the 16-bit destination offset (Y), a 16-bit count holding the byte total minus one, and the direction. The sequencer then moves the block one byte at a time over a single synchronous memory port. Each byte is a full re-execution of the instruction: three fetch cycles, a source read, a destination write and two internal cycles, so every byte takes seven cycles.

Between bytes the sequencer looks at a pending-interrupt input. If an interrupt is waiting and bytes remain, it stops. In that case it reports that the instruction must be re-executed and hands back an instruction address rewound to the opcode, so the core can service the interrupt and then restart the move from the updated registers. When the last byte is done, it reports completion and hands back the address just past the instruction. Offsets wrap inside their 64 KiB bank, and the bank bytes never change during the move. At the end, the destination bank is left in the data-bank output.

Top module: `blkmv_seq`

## Requirements
- R1: After reset, `busy`, `reexec`, `beat_end`, `mem_rd` and `mem_wr` are 0, and `x_out`, `y_out`, `cnt_out`, `dbank_out` and `pc_out` are 0.
- R2: Each byte is read from address {source bank, X} and written unchanged to address {destination bank, Y}. The destination bank is the instruction byte at opcode address + 1, and the source bank is the byte at opcode address + 2.
- R3: After each byte, the count decrements by one. X and Y both increment when `dir_desc` = 0 and both decrement when `dir_desc` = 1.
- R4: The move completes after the byte in which the count steps from 0x0000 to 0xFFFF. For example, count 0x0FFE, X 0x1000 and Y 0x1001 ends with count 0xFFFF, X 0x1FFF and Y 0x2000.
- R5: Each byte takes exactly 7 cycles, and `beat_end` is high on the 7th cycle only. A move of N bytes that is not interrupted holds `busy` high for 7·N cycles.
- R6: Within a byte, the bus cycles occur in this order: a read at the opcode address, a read at opcode+1, a read at opcode+2, the source read, the destination write, then two cycles with neither `mem_rd` nor `mem_wr` set. `mem_rd` and `mem_wr` are never high together.
- R7: X and Y wrap from 0xFFFF to 0x0000 (or from 0x0000 to 0xFFFF when descending) inside their bank. The bank byte of the source and destination addresses never changes during the move.
- R8: `dbank_out` holds the destination bank once the move has started, and it keeps that value after the move ends.
- R9: `irq_pend` is sampled on the last cycle of a byte. If it is high and bytes remain, the sequencer stops with `reexec` = 1 and `pc_out` equal to the opcode address. If the move is complete, it stops with `reexec` = 0 and `pc_out` equal to the opcode address + 3, whatever `irq_pend` is.
- R10: Overlapping ranges are copied strictly in byte order. An ascending move with Y = X + 1 copies the first byte across the whole range.
- R11: A starting count of 0xFFFF is an ordinary 65536-byte move. After its first byte the count is 0xFFFE and the move is not complete.
- R12: `start` is ignored while `busy` is high, so the registers in use are not reloaded.
- R13: `irq_pend` that is high only during cycles other than the last cycle of a byte has no effect on the move.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin executing the instruction; sampled when idle |
| dir_desc | input | 1 | 0 = ascending, 1 = descending |
| pc_in | input | 24 | Address of the opcode byte |
| x_in | input | 16 | Source offset |
| y_in | input | 16 | Destination offset |
| cnt_in | input | 16 | Bytes to move minus one |
| irq_pend | input | 1 | Interrupt pending, sampled at the end of each byte |
| mem_addr | output | 24 | Memory address |
| mem_rd | output | 1 | Read request; data returns on `mem_rdata` the next cycle |
| mem_wr | output | 1 | Write request |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data from the previous cycle's read |
| busy | output | 1 | Move in progress |
| reexec | output | 1 | Last stop left bytes to move; the instruction must run again |
| beat_end | output | 1 | Last cycle of a byte |
| beat_more | output | 1 | With `beat_end`: another byte follows |
| x_out | output | 16 | Current source offset |
| y_out | output | 16 | Current destination offset |
| cnt_out | output | 16 | Current count |
| dbank_out | output | 8 | Data bank, loaded with the destination bank |
| pc_out | output | 24 | Instruction address handed back at stop |

## Verification
The main function is exercised with short ascending and descending copies across two banks, a copy whose offsets cross the 0xFFFF boundary, a fill made from an overlap of one byte, and the long example whose final register values are known. The ascending and descending copies tell the direction of the offset steps apart, and the boundary copy shows whether the offsets wrap or carry into the bank byte. The fill shows that the bytes are copied strictly in order rather than in bulk. Interrupt patterns tell apart a stop between bytes, a request raised on the final byte, a pulse in the middle of a byte and a restart after a stop. A bus trace of one byte checks the cycle order and the addresses.

// File: rtl/blkmv_pkg.sv
package blkmv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FOP,
    ST_FDB,
    ST_FSB,
    ST_RSRC,
    ST_WDST,
    ST_UPD1,
    ST_UPD2
  } mv_state_t;
endpackage

// File: rtl/blkmv_ofs.sv
// One 16-bit offset/count register: load, then step up or down with natural wrap.
module blkmv_ofs #(
  parameter int OFS_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic             dec,
  input  logic [OFS_W-1:0] d_in,
  output logic [OFS_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (load) begin
      q <= d_in;
    end else if (step) begin
      q <= dec ? q - 1'b1 : q + 1'b1;
    end
  end
endmodule

// File: rtl/blkmv_regs.sv
// Architectural state touched by the move: offsets, count, banks, instruction address.
module blkmv_regs #(
  parameter int OFS_W     = 16,
  parameter int BANK_W    = 8,
  parameter int INSTR_LEN = 3,
  localparam int ADDR_W   = BANK_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic              dbank_wr,
  input  logic              sbank_wr,
  input  logic              fin,
  input  logic              fin_rewind,
  input  logic              desc_in,
  input  logic [OFS_W-1:0]  x_in,
  input  logic [OFS_W-1:0]  y_in,
  input  logic [OFS_W-1:0]  cnt_in,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [BANK_W-1:0] bank_d,
  output logic [OFS_W-1:0]  x_q,
  output logic [OFS_W-1:0]  y_q,
  output logic [OFS_W-1:0]  cnt_q,
  output logic [BANK_W-1:0] dbank_q,
  output logic [BANK_W-1:0] sbank_q,
  output logic [ADDR_W-1:0] pc_q,
  output logic [ADDR_W-1:0] pc_out_q,
  output logic              cnt_wrapped
);
  localparam int N_REG = 3;
  localparam int I_CNT = N_REG - 1;

  logic             desc_q;
  logic [OFS_W-1:0] ld_v [N_REG];
  logic [OFS_W-1:0] cur  [N_REG];

  assign ld_v[0] = x_in;
  assign ld_v[1] = y_in;
  assign ld_v[2] = cnt_in;

  genvar gi;
  generate
    for (gi = 0; gi < N_REG; gi++) begin : g_ofs
      logic dec_sel;
      if (gi == I_CNT) begin : g_cnt
        assign dec_sel = 1'b1;
      end else begin : g_idx
        assign dec_sel = desc_q;
      end
      blkmv_ofs #(.OFS_W(OFS_W)) u_ofs (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .step (step),
        .dec  (dec_sel),
        .d_in (ld_v[gi]),
        .q    (cur[gi])
      );
    end
  endgenerate

  assign x_q         = cur[0];
  assign y_q         = cur[1];
  assign cnt_q       = cur[I_CNT];
  assign cnt_wrapped = (cnt_q == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      desc_q   <= 1'b0;
      dbank_q  <= '0;
      sbank_q  <= '0;
      pc_q     <= '0;
      pc_out_q <= '0;
    end else begin
      if (load) begin
        desc_q <= desc_in;
        pc_q   <= pc_in;
      end
      if (dbank_wr) dbank_q <= bank_d;
      if (sbank_wr) sbank_q <= bank_d;
      if (fin) begin
        pc_out_q <= fin_rewind ? pc_q
                  : {pc_q[ADDR_W-1:OFS_W], pc_q[OFS_W-1:0] + OFS_W'(INSTR_LEN)};
      end
    end
  end

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    step |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R7
  x_bank_stay_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !desc_in && !load && !desc_q) |=> (x_q == $past(x_q) + 1'b1));
endmodule

// File: rtl/blkmv_ctrl.sv
// Seven-cycle per-byte sequencer with interrupt checkpoint on the last cycle.
module blkmv_ctrl
  import blkmv_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  input  logic      irq_pend,
  input  logic      cnt_wrapped,
  output mv_state_t state_q,
  output logic      load,
  output logic      step,
  output logic      dbank_wr,
  output logic      sbank_wr,
  output logic      fin,
  output logic      fin_rewind,
  output logic      beat_end,
  output logic      beat_more,
  output logic      busy_q,
  output logic      reexec_q
);
  mv_state_t state_d;

  always_comb begin
    load       = (state_q == ST_IDLE) && start;
    dbank_wr   = (state_q == ST_FSB);
    sbank_wr   = (state_q == ST_RSRC);
    step       = (state_q == ST_UPD1);
    beat_end   = (state_q == ST_UPD2);
    beat_more  = beat_end && !cnt_wrapped;
    fin        = beat_end && (!beat_more || irq_pend);
    fin_rewind = beat_more;
    case (state_q)
      ST_IDLE: state_d = start ? ST_FOP : ST_IDLE;
      ST_FOP:  state_d = ST_FDB;
      ST_FDB:  state_d = ST_FSB;
      ST_FSB:  state_d = ST_RSRC;
      ST_RSRC: state_d = ST_WDST;
      ST_WDST: state_d = ST_UPD1;
      ST_UPD1: state_d = ST_UPD2;
      ST_UPD2: state_d = fin ? ST_IDLE : ST_FOP;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      busy_q   <= 1'b0;
      reexec_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (load) begin
        busy_q   <= 1'b1;
        reexec_q <= 1'b0;
      end else if (fin) begin
        busy_q   <= 1'b0;
        reexec_q <= fin_rewind;
      end
    end
  end

  // R9
  reexec_irq_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(reexec_q) |-> $past(irq_pend));

  // R5
  fetch_after_end_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FOP) |-> ($past(state_q) == ST_UPD2 || $past(state_q) == ST_IDLE));
endmodule

// File: rtl/blkmv_seq.sv
// Top: block-move sequencer with one synchronous memory port.
module blkmv_seq
  import blkmv_pkg::*;
#(
  parameter int OFS_W     = 16,
  parameter int BANK_W    = 8,
  parameter int DATA_W    = 8,
  parameter int INSTR_LEN = 3,
  localparam int ADDR_W   = BANK_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              dir_desc,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [OFS_W-1:0]  x_in,
  input  logic [OFS_W-1:0]  y_in,
  input  logic [OFS_W-1:0]  cnt_in,
  input  logic              irq_pend,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              reexec,
  output logic              beat_end,
  output logic              beat_more,
  output logic [OFS_W-1:0]  x_out,
  output logic [OFS_W-1:0]  y_out,
  output logic [OFS_W-1:0]  cnt_out,
  output logic [BANK_W-1:0] dbank_out,
  output logic [ADDR_W-1:0] pc_out
);
  mv_state_t         state;
  logic              load, step, dbank_wr, sbank_wr, fin, fin_rewind, cnt_wrapped;
  logic [BANK_W-1:0] sbank;
  logic [ADDR_W-1:0] pc_cur;

  blkmv_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .irq_pend    (irq_pend),
    .cnt_wrapped (cnt_wrapped),
    .state_q     (state),
    .load        (load),
    .step        (step),
    .dbank_wr    (dbank_wr),
    .sbank_wr    (sbank_wr),
    .fin         (fin),
    .fin_rewind  (fin_rewind),
    .beat_end    (beat_end),
    .beat_more   (beat_more),
    .busy_q      (busy),
    .reexec_q    (reexec)
  );

  blkmv_regs #(.OFS_W(OFS_W), .BANK_W(BANK_W), .INSTR_LEN(INSTR_LEN)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .load        (load),
    .step        (step),
    .dbank_wr    (dbank_wr),
    .sbank_wr    (sbank_wr),
    .fin         (fin),
    .fin_rewind  (fin_rewind),
    .desc_in     (dir_desc),
    .x_in        (x_in),
    .y_in        (y_in),
    .cnt_in      (cnt_in),
    .pc_in       (pc_in),
    .bank_d      (mem_rdata[BANK_W-1:0]),
    .x_q         (x_out),
    .y_q         (y_out),
    .cnt_q       (cnt_out),
    .dbank_q     (dbank_out),
    .sbank_q     (sbank),
    .pc_q        (pc_cur),
    .pc_out_q    (pc_out),
    .cnt_wrapped (cnt_wrapped)
  );

  function automatic logic [ADDR_W-1:0] fetch_addr(input logic [ADDR_W-1:0] base,
                                                   input int unsigned k);
    return {base[ADDR_W-1:OFS_W], base[OFS_W-1:0] + OFS_W'(k)};
  endfunction

  always_comb begin
    mem_addr  = '0;
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_wdata = mem_rdata;
    case (state)
      ST_FOP:  begin mem_addr = fetch_addr(pc_cur, 0); mem_rd = 1'b1; end
      ST_FDB:  begin mem_addr = fetch_addr(pc_cur, 1); mem_rd = 1'b1; end
      ST_FSB:  begin mem_addr = fetch_addr(pc_cur, 2); mem_rd = 1'b1; end
      ST_RSRC: begin mem_addr = {mem_rdata[BANK_W-1:0], x_out}; mem_rd = 1'b1; end
      ST_WDST: begin mem_addr = {dbank_out, y_out}; mem_wr = 1'b1; end
      default: ;
    endcase
  end

  // R6
  rw_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  // R6
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> $past(mem_rd));

  // R7
  src_bank_kept_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> ($past(mem_addr[ADDR_W-1:OFS_W]) == sbank));

  // R5
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(beat_end));
endmodule

// File: tb/blkmv_seq_bench.sv
module blkmv_seq_bench;
  localparam int CLK_PER = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        dir_desc = 1'b0;
  logic [23:0] pc_in = '0;
  logic [15:0] x_in = '0, y_in = '0, cnt_in = '0;
  logic        irq_pend = 1'b0;
  logic [23:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        busy, reexec, beat_end, beat_more;
  logic [15:0] x_out, y_out, cnt_out;
  logic [7:0]  dbank_out;
  logic [23:0] pc_out;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #(CLK_PER/2) clk = ~clk;

  blkmv_seq u_blkmv_seq (
    .clk(clk), .rst(rst), .start(start), .dir_desc(dir_desc), .pc_in(pc_in),
    .x_in(x_in), .y_in(y_in), .cnt_in(cnt_in), .irq_pend(irq_pend),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .reexec(reexec), .beat_end(beat_end),
    .beat_more(beat_more), .x_out(x_out), .y_out(y_out), .cnt_out(cnt_out),
    .dbank_out(dbank_out), .pc_out(pc_out)
  );

  // sparse memory model with one-cycle read latency
  logic [7:0] bmem [logic [23:0]];

  function automatic logic [7:0] peek(input logic [23:0] a);
    return bmem.exists(a) ? bmem[a] : 8'h00;
  endfunction

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= peek(mem_addr);
    if (mem_wr) bmem[mem_addr] = mem_wdata;
  end

  // bus trace
  logic        tr_on = 1'b0;
  int          tr_n = 0;
  logic [23:0] tr_addr [16];
  logic        tr_rd [16];
  logic        tr_wr [16];
  logic        tr_end [16];

  always @(posedge clk) begin
    if (tr_on && busy && tr_n < 16) begin
      tr_addr[tr_n] = mem_addr;
      tr_rd[tr_n]   = mem_rd;
      tr_wr[tr_n]   = mem_wr;
      tr_end[tr_n]  = beat_end;
      tr_n++;
    end
  end

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      bad++;
      $display("FAIL R5 watchdog act=%0d exp=<190000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic put_code(input logic [23:0] pc, input logic [7:0] db, input logic [7:0] sb);
    bmem[pc] = 8'h54;
    bmem[pc + 24'd1] = db;
    bmem[pc + 24'd2] = sb;
  endtask

  // irq_mode: 0 none, 1 always high, 2 high only at cycle index irq_at
  task automatic run(input logic desc, input logic [23:0] pc, input logic [15:0] x,
                     input logic [15:0] y, input logic [15:0] c, input int irq_mode,
                     input int irq_at, input int restart_at, output int ncyc);
    @(negedge clk);
    dir_desc = desc; pc_in = pc; x_in = x; y_in = y; cnt_in = c;
    irq_pend = (irq_mode == 1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ncyc = 0;
    while (busy && ncyc < 40000) begin
      irq_pend = (irq_mode == 1) || (irq_mode == 2 && ncyc == irq_at);
      if (ncyc == restart_at) begin
        start = 1'b1; x_in = 16'hDEAD; cnt_in = 16'h0000;
      end else begin
        start = 1'b0;
      end
      ncyc++;
      @(negedge clk);
    end
    start = 1'b0;
    irq_pend = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 reexec", reexec, 0);
    chk("R1 beat_end", beat_end, 0);
    chk("R1 rd/wr", {mem_rd, mem_wr}, 0);
    chk("R1 regs", {x_out, y_out}, 0);
    chk("R1 cnt/bank", {cnt_out, dbank_out}, 0);
    chk("R1 pc_out", pc_out, 0);
  endtask

  task automatic t_asc_copy();
    int n;
    bmem.delete();
    put_code(24'h000010, 8'h03, 8'h02);
    for (int i = 0; i < 4; i++) bmem[24'h020100 + 24'(i)] = 8'hA0 + 8'(i);
    run(1'b0, 24'h000010, 16'h0100, 16'h0200, 16'd3, 0, -1, -1, n);
    for (int i = 0; i < 4; i++)
      chk("R2 asc data", peek(24'h030200 + 24'(i)), 8'hA0 + 8'(i));
    chk("R3 asc x", x_out, 16'h0104);
    chk("R3 asc y", y_out, 16'h0204);
    chk("R4 asc cnt", cnt_out, 16'hFFFF);
    chk("R5 asc cycles", n, 28);
    chk("R8 dbank", dbank_out, 8'h03);
    chk("R9 complete reexec", reexec, 0);
    chk("R9 complete pc", pc_out, 24'h000013);
  endtask

  task automatic t_desc_copy();
    int n;
    bmem.delete();
    put_code(24'h000020, 8'h07, 8'h06);
    for (int i = 3; i <= 5; i++) bmem[24'h060100 + 24'(i)] = 8'h30 + 8'(i);
    run(1'b1, 24'h000020, 16'h0105, 16'h0305, 16'd2, 0, -1, -1, n);
    for (int i = 3; i <= 5; i++)
      chk("R2 desc data", peek(24'h070300 + 24'(i)), 8'h30 + 8'(i));
    chk("R3 desc x", x_out, 16'h0102);
    chk("R3 desc y", y_out, 16'h0302);
    chk("R3 desc cnt", cnt_out, 16'hFFFF);
    chk("R5 desc cycles", n, 21);
  endtask

  task automatic t_trace();
    int n;
    bmem.delete();
    put_code(24'h000040, 8'h06, 8'h05);
    bmem[24'h050010] = 8'h77;
    tr_n = 0; tr_on = 1'b1;
    run(1'b0, 24'h000040, 16'h0010, 16'h0020, 16'h0000, 0, -1, -1, n);
    tr_on = 1'b0;
    chk("R6 trace len", tr_n, 7);
    chk("R6 c0", {tr_rd[0], tr_wr[0], tr_addr[0]}, {2'b10, 24'h000040});
    chk("R6 c1", {tr_rd[1], tr_wr[1], tr_addr[1]}, {2'b10, 24'h000041});
    chk("R6 c2", {tr_rd[2], tr_wr[2], tr_addr[2]}, {2'b10, 24'h000042});
    chk("R2 src read", {tr_rd[3], tr_wr[3], tr_addr[3]}, {2'b10, 24'h050010});
    chk("R2 dst write", {tr_rd[4], tr_wr[4], tr_addr[4]}, {2'b01, 24'h060020});
    chk("R6 idle", {tr_rd[5], tr_wr[5], tr_rd[6], tr_wr[6]}, 0);
    chk("R5 beat_end pos", {tr_end[0], tr_end[1], tr_end[2], tr_end[3],
                            tr_end[4], tr_end[5], tr_end[6]}, 7'b0000001);
    chk("R2 data", peek(24'h060020), 8'h77);
  endtask

  task automatic t_wrap();
    int n;
    bmem.delete();
    put_code(24'h000050, 8'h03, 8'h02);
    bmem[24'h02FFFF] = 8'h11; bmem[24'h020000] = 8'h22; bmem[24'h020001] = 8'h33;
    run(1'b0, 24'h000050, 16'hFFFF, 16'hFFFE, 16'd2, 0, -1, -1, n);
    chk("R7 wrap d0", peek(24'h03FFFE), 8'h11);
    chk("R7 wrap d1", peek(24'h03FFFF), 8'h22);
    chk("R7 wrap d2", peek(24'h030000), 8'h33);
    chk("R7 no carry", peek(24'h040000), 8'h00);
    chk("R7 x", x_out, 16'h0002);
    chk("R7 y", y_out, 16'h0001);
  endtask

  task automatic t_fill();
    int n;
    bmem.delete();
    put_code(24'h000060, 8'h01, 8'h01);
    bmem[24'h010400] = 8'h5A;
    run(1'b0, 24'h000060, 16'h0400, 16'h0401, 16'h000E, 0, -1, -1, n);
    for (int i = 1; i <= 15; i++)
      chk("R10 fill", peek(24'h010400 + 24'(i)), 8'h5A);
    chk("R10 beyond", peek(24'h010410), 8'h00);
  endtask

  task automatic t_irq_stop();
    int n;
    bmem.delete();
    put_code(24'h000070, 8'h09, 8'h08);
    for (int i = 0; i < 5; i++) bmem[24'h080000 + 24'(i)] = 8'hC0 + 8'(i);
    run(1'b0, 24'h000070, 16'h0000, 16'h0100, 16'd4, 1, -1, -1, n);
    chk("R9 stop cycles", n, 7);
    chk("R9 reexec", reexec, 1);
    chk("R9 rewind pc", pc_out, 24'h000070);
    chk("R9 cnt", cnt_out, 16'd3);
    chk("R9 x", x_out, 16'h0001);
    chk("R9 one byte", {peek(24'h090100), peek(24'h090101)}, {8'hC0, 8'h00});
    run(1'b0, pc_out, x_out, y_out, cnt_out, 0, -1, -1, n);
    chk("R9 resume cycles", n, 28);
    chk("R9 resume reexec", reexec, 0);
    for (int i = 0; i < 5; i++)
      chk("R9 resume data", peek(24'h090100 + 24'(i)), 8'hC0 + 8'(i));
    run(1'b0, 24'h000070, 16'h0000, 16'h0200, 16'd0, 1, -1, -1, n);
    chk("R9 last byte reexec", reexec, 0);
    chk("R9 last byte pc", pc_out, 24'h000073);
  endtask

  task automatic t_irq_mid();
    int n;
    bmem.delete();
    put_code(24'h000080, 8'h09, 8'h08);
    run(1'b0, 24'h000080, 16'h0000, 16'h0100, 16'd1, 2, 2, -1, n);
    chk("R13 cycles", n, 14);
    chk("R13 reexec", reexec, 0);
    chk("R13 cnt", cnt_out, 16'hFFFF);
  endtask

  task automatic t_full_count();
    int n;
    bmem.delete();
    put_code(24'h000090, 8'h00, 8'h00);
    run(1'b0, 24'h000090, 16'h2000, 16'h3000, 16'hFFFF, 1, -1, -1, n);
    chk("R11 cnt", cnt_out, 16'hFFFE);
    chk("R11 not done", reexec, 1);
    chk("R11 cycles", n, 7);
  endtask

  task automatic t_start_busy();
    int n;
    bmem.delete();
    put_code(24'h0000A0, 8'h04, 8'h04);
    run(1'b0, 24'h0000A0, 16'h0500, 16'h0600, 16'd2, 0, -1, 3, n);
    chk("R12 cycles", n, 21);
    chk("R12 x", x_out, 16'h0503);
    chk("R12 cnt", cnt_out, 16'hFFFF);
  endtask

  task automatic t_example();
    int n;
    bmem.delete();
    put_code(24'h000010, 8'h00, 8'h00);
    bmem[24'h001000] = 8'hC3;
    run(1'b0, 24'h000010, 16'h1000, 16'h1001, 16'h0FFE, 0, -1, -1, n);
    chk("R4 example cnt", cnt_out, 16'hFFFF);
    chk("R4 example x", x_out, 16'h1FFF);
    chk("R4 example y", y_out, 16'h2000);
    chk("R5 example cycles", n, 4095 * 7);
    chk("R10 example fill", peek(24'h001FFF), 8'hC3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_asc_copy();
    t_desc_copy();
    t_trace();
    t_wrap();
    t_fill();
    t_irq_stop();
    t_irq_mid();
    t_full_count();
    t_start_busy();
    t_example();
    summary();
    $finish;
  end
endmodule